// File: doc/BRIEF.md
# Predicated Tree Vector Reducer

The reducer folds up to `LANES` integer elements into one scalar by pairwise addition in a fixed binary-tree order. Each element carries an enable bit, and the caller also gives an active length. Lanes that are disabled, or that sit at or above the active length, take no part in the sum. The tree still runs in full, and an enabled value moves down into a disabled slot, so the pairing order never depends on the enable pattern.

A `start_i` strobe captures the elements, the enables and the length into working registers. The block then runs one pass per clock, with the stride doubling on each pass, until the stride reaches the active length. After that it raises `done_o` for one cycle, together with a registered `result_o` and `valid_o`. `valid_o` is low, and the result is zero, when no lane was enabled or the length was zero. The pairing is fixed, so the same inputs always combine in the same order; this keeps results repeatable for operators that are not associative. The operator here is wrapping addition.

Top module: `tree_reducer`

## Requirements
- R1: On an accepted start, lane j of the working set is enabled only if `mask_i[j]` is 1 and j is below the effective length. An enabled lane loads element j from `elem_i[j*WIDTH +: WIDTH]`. A disabled lane loads zero.
- R2: A `len_i` above `LANES` is treated as `LANES`.
- R3: P is the smallest p with 2^p >= effective length, and P is 0 for a length of 0 or 1. For a start sampled at clock edge 0, the block runs its passes at edges 1..P and raises `done_o` after edge P+1.
- R4: In the pass with half-stride h, lane i (a multiple of 2h) is paired with lane i+h. When both are enabled, lane i becomes lane i plus lane i+h, modulo 2^WIDTH.
- R5: When only partner i+h is enabled, lane i takes the partner's value. After the pass, lane i's enable is the OR of its own enable and the partner's.
- R6: With `valid_o` high, `result_o` equals the sum, modulo 2^WIDTH, of all enabled elements below the effective length.
- R7: If the effective length is 0 or no lane below it is enabled, `done_o` is raised with `valid_o` = 0 and `result_o` = 0.
- R8: `done_o` is high for exactly one cycle per accepted start. `result_o` and `valid_o` hold their values until the next `done_o`.
- R9: A `start_i` that arrives while a reduction is in progress, up to and including its final cycle, is ignored. Neither the current result nor the number of `done_o` pulses changes.
- R10: While `rst_ni` is low, `done_o`, `valid_o` and `result_o` are 0 and no reduction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a reduction (ignored while busy) |
| len_i | input | $clog2(LANES+1) | Active length |
| elem_i | input | LANES*WIDTH | Packed elements, lane j at bits j*WIDTH |
| mask_i | input | LANES | Per-lane enable |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Reduced value, 0 when not valid |
| valid_o | output | 1 | At least one lane contributed |

## Verification
The bench covers every enable pattern for every length from 0 to 10 and also length 15. Elements are chosen so that the sums wrap. A design that left a slot unchanged when only its upper partner was enabled would drop that partner and give a short sum. A design that ignored the length would pick up enabled lanes beyond it. Timing is checked against P+2 sampled cycles, which exposes an off-by-one in the stride comparison: one pass too few loses the top half of the vector. A start issued during a reduction must not change its result or add a `done_o` pulse. An empty or zero-length vector must give `valid_o` low with a zero result rather than stale data.

// File: rtl/tree_reducer_pkg.sv
package tree_reducer_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  function automatic int unsigned pass_count(int unsigned len);
    int unsigned p = 0;
    while ((1 << p) < len) p++;
    return p;
  endfunction
endpackage

// File: rtl/tr_pair.sv
module tr_pair #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             act_i,
  input  logic [WIDTH-1:0] own_val_i,
  input  logic             own_en_i,
  input  logic [WIDTH-1:0] prt_val_i,
  input  logic             prt_en_i,
  output logic [WIDTH-1:0] val_o,
  output logic             en_o
);
  always_comb begin
    val_o = own_val_i;
    en_o  = own_en_i;
    if (act_i) begin
      if (own_en_i && prt_en_i) val_o = own_val_i + prt_val_i;
      else if (prt_en_i)        val_o = prt_val_i;
      en_o = own_en_i | prt_en_i;
    end
  end
endmodule

// File: rtl/tr_seq.sv
module tr_seq
  import tree_reducer_pkg::*;
#(
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned PASS_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_q_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              step_o,
  output logic              finish_o,
  output logic [PASS_W-1:0] pass_o
);
  seq_state_e        state_q;
  logic [PASS_W-1:0] pass_q;
  logic [LEN_W:0]    stride;

  assign stride   = {{LEN_W{1'b0}}, 1'b1} << pass_q;
  assign busy_o   = (state_q == ST_RUN);
  assign load_o   = start_i && !busy_o;
  assign step_o   = busy_o && (stride < {1'b0, len_q_i});
  assign finish_o = busy_o && !step_o;
  assign pass_o   = pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      pass_q  <= '0;
    end else if (step_o) begin
      pass_q  <= pass_q + 1'b1;
    end else if (finish_o) begin
      state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/tree_reducer.sv
module tree_reducer #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned LEN_W  = $clog2(LANES + 1),
  localparam int unsigned PASS_W = $clog2(IDX_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [LANES*WIDTH-1:0] elem_i,
  input  logic [LANES-1:0]       mask_i,
  output logic                   done_o,
  output logic [WIDTH-1:0]       result_o,
  output logic                   valid_o
);
  logic [WIDTH-1:0]  vals_q [LANES];
  logic [WIDTH-1:0]  vals_d [LANES];
  logic [LANES-1:0]  mask_q, mask_d;
  logic [LEN_W-1:0]  len_q, len_eff;
  logic              busy, load, step, finish;
  logic [PASS_W-1:0] pass;
  logic              done_q, valid_q;
  logic [WIDTH-1:0]  res_q;

  // R2: clamp oversize length
  assign len_eff = (len_i > LEN_W'(LANES)) ? LEN_W'(LANES) : len_i;

  tr_seq #(.LEN_W(LEN_W), .PASS_W(PASS_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .len_q_i (len_q),
    .busy_o  (busy),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish),
    .pass_o  (pass)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WIDTH-1:0] prt_val;
    logic             prt_en, act;

    always_comb begin
      prt_val = '0;
      prt_en  = 1'b0;
      act     = 1'b0;
      for (int p = 0; p < IDX_W; p++) begin
        if (PASS_W'(p) == pass && (i % (2 << p)) == 0 && (i + (1 << p)) < LANES) begin
          act     = step;
          prt_val = vals_q[(i + (1 << p)) % LANES];
          prt_en  = mask_q[(i + (1 << p)) % LANES]
                    && (LEN_W'(i + (1 << p)) < len_q);
        end
      end
    end

    tr_pair #(.WIDTH(WIDTH)) u_pair (
      .act_i    (act),
      .own_val_i(vals_q[i]),
      .own_en_i (mask_q[i]),
      .prt_val_i(prt_val),
      .prt_en_i (prt_en),
      .val_o    (vals_d[i]),
      .en_o     (mask_d[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vals_q[i] <= '0;
        mask_q[i] <= 1'b0;
      end else if (load) begin
        mask_q[i] <= mask_i[i] && (LEN_W'(i) < len_eff);
        vals_q[i] <= (mask_i[i] && (LEN_W'(i) < len_eff)) ? elem_i[i*WIDTH +: WIDTH] : '0;
      end else if (step) begin
        mask_q[i] <= mask_d[i];
        vals_q[i] <= vals_d[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= finish;
      if (load) len_q <= len_eff;
      if (finish) begin
        valid_q <= (len_q != '0) && mask_q[0];
        res_q   <= ((len_q != '0) && mask_q[0]) ? vals_q[0] : '0;
      end
    end
  end

  assign done_o   = done_q;
  assign valid_o  = valid_q;
  assign result_o = res_q;
endmodule

// File: rtl/tree_reducer_chk.sv
module tree_reducer_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned LEN_W = $clog2(LANES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic [LANES-1:0] mask_i,
  input logic             done_o,
  input logic             valid_o,
  input logic [WIDTH-1:0] result_o,
  input logic             busy_i,
  input logic [LEN_W-1:0] len_q_i
);
  logic       accept, en_q;
  logic [7:0] cnt_q;
  logic [LANES-1:0] in_range;

  assign accept = start_i && !busy_i;
  always_comb
    for (int j = 0; j < LANES; j++) in_range[j] = (j < int'(len_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (accept) begin
      cnt_q <= 8'd1;
      en_q  <= |(mask_i & in_range);
    end else if (busy_i) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> result_o == '0); // R7
  AST_EMPTY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && len_i == '0) |=> ##1 (done_o && !valid_o)); // R7
  AST_VALID_HAS_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> en_q); // R6
  AST_PASS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> cnt_q <= 8'(IDX_W + 1)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> len_q_i == $past(len_q_i)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!done_o && !valid_o && result_o == '0 && !busy_i)); // R10
endmodule

bind tree_reducer tree_reducer_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
  .clk_i, .rst_ni, .start_i, .len_i, .mask_i, .done_o, .valid_o, .result_o,
  .busy_i (busy),
  .len_q_i(len_q)
);

// File: tb/tree_reducer_tb_top.sv
module tree_reducer_tb_top;
  localparam int unsigned LANES = 8;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned LEN_W = $clog2(LANES + 1);

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   start_i = 1'b0;
  logic [LEN_W-1:0]       len_i = '0;
  logic [LANES*WIDTH-1:0] elem_i = '0;
  logic [LANES-1:0]       mask_i = '0;
  logic                   done_o, valid_o;
  logic [WIDTH-1:0]       result_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  tree_reducer #(.LANES(LANES), .WIDTH(WIDTH)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int passes(int eff);
    int p = 0;
    while ((1 << p) < eff) p++;
    return p;
  endfunction

  task automatic run_one(input int len, input int mask, input int seed);
    int eff, exp_sum, k, np;
    bit any;
    eff = (len > LANES) ? LANES : len;
    exp_sum = 0;
    any = 0;
    for (int j = 0; j < LANES; j++) begin
      elem_i[j*WIDTH +: WIDTH] = WIDTH'(seed * 40503 + j * 9973 + 30011);
      if (mask[j] && j < eff) begin
        exp_sum = (exp_sum + int'(elem_i[j*WIDTH +: WIDTH])) & 16'hffff;
        any = 1;
      end
    end
    len_i   = LEN_W'(len);
    mask_i  = LANES'(mask);
    start_i = 1'b1;
    k = 0;
    np = passes(eff);
    do begin
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      k++;
    end while (!done_o && k < 20);
    check(k == np + 2, "R3 latency", k, np + 2);
    check(valid_o == any, "R7 valid", valid_o, any);
    check(int'(result_o) == (any ? exp_sum : 0), "R6 R4 R5 R1 R2 result",
          result_o, any ? exp_sum : 0);
    @(posedge clk_i);
    @(negedge clk_i);
    check(!done_o, "R8 pulse", done_o, 0);
    check(int'(result_o) == (any ? exp_sum : 0), "R8 hold", result_o, any ? exp_sum : 0);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 1;
    int cnt, exp1;
    repeat (3) @(negedge clk_i);
    check(!done_o && !valid_o && result_o == 0, "R10 reset", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int len = 0; len <= 11; len++) begin
      for (int mask = 0; mask < 256; mask++) begin
        run_one(len == 11 ? 15 : len, mask, seed);
        seed++;
      end
    end

    // R9: start while busy, then at the final cycle
    for (int j = 0; j < LANES; j++) elem_i[j*WIDTH +: WIDTH] = WIDTH'(j + 1);
    exp1 = 36;
    len_i = LEN_W'(8);
    mask_i = 8'hff;
    start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    elem_i = '1;
    mask_i = 8'h01;
    len_i = LEN_W'(1);
    cnt = 0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (c == 3) start_i = 1'b0;
      if (done_o) begin
        cnt++;
        check(result_o == WIDTH'(exp1) && valid_o, "R9 result kept", result_o, exp1);
      end
    end
    check(cnt == 1, "R9 single done", cnt, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule